// File: doc/BRIEF.md
# Tiled Aperture Fence Decoder

This block holds a small set of fence registers. Each fence marks one window of a linear aperture whose contents are laid out in memory as X tiles or Y tiles. Every incoming linear address is compared against all enabled fences at once. When a fence claims the address, the block rewrites it into the tiled location using that fence's stride and tile format. An address that no fence claims leaves the block unchanged. The result appears one clock after the request.

Software reaches the fences through a 32-bit write port and a 32-bit read port. Each 64-bit fence is split into a low word and a high word, and the word address is `{fence index, half}`, where half 0 is the low word and half 1 is the high word. Only the low word carries the enable bit, so a fence that is half written cannot claim addresses. The safe sequence is: zero the low word, write the high word, then write the low word with the enable set. To clear a fence, zero the low word and then the high word. Before it computes the last page, software trims the window size down to a whole number of tile rows. A tile row is stride × 8 bytes for X tiling and stride × 32 bytes for Y tiling.

Top module: `fence_decoder`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rsp_valid`, `rsp_hit` and `cfg_rdata` are 0. Every fence is disabled and every word reads back as 0.
- R2: The low word is laid out as follows: bits [31:12] hold the start page, bits [11:2] hold the pitch code (stride/128 − 1), bit 1 selects Y tiling (0 means X tiling) and bit 0 enables the fence. The high word keeps bits [31:12] as the last page of the window, and its bits [11:0] read as 0. `cfg_rdata` returns the addressed word one cycle after `cfg_raddr`.
- R3: A fence whose enable bit is 0 never claims an address. This holds whatever has been written to its high word, including the point in the safe sequence just after the high word is written.
- R4: An enabled fence claims an address when start page ≤ address[31:12] ≤ last page. Both bounds are inclusive.
- R5: When several fences claim an address, `rsp_fence` reports the one with the lowest index.
- R6: When no fence claims an address, `rsp_hit` is 0 and `rsp_addr` equals the request address.
- R7: X tiling uses tiles 512 bytes wide by 8 rows. For offset o = addr − start, stride S, y = o / S and x = o mod S, the result is start + ((y/8)·(S/512) + x/512)·4096 + (y mod 8)·512 + (x mod 512). The X stride is a multiple of 512.
- R8: Y tiling uses tiles 128 bytes wide by 32 rows, stored as 16-byte columns. The result is start + ((y/32)·(S/128) + x/128)·4096 + ((x mod 128)/16)·512 + (y mod 32)·16 + (x mod 16).
- R9: `rsp_valid` follows `req_valid` exactly one cycle later, and `rsp_addr`, `rsp_hit` and `rsp_fence` belong to the request of the previous cycle.
- R10: A register write lands in one cycle. A request in the cycle after a low-word write already uses the new fence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | WSEL_W | Write word address {fence index, half} |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | WSEL_W | Read word address {fence index, half} |
| cfg_rdata | output | 32 | Read data, one cycle after cfg_raddr |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 32 | Linear aperture address |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_addr | output | 32 | Translated (or passed-through) address |
| rsp_hit | output | 1 | A fence claimed the address |
| rsp_fence | output | IDX_W | Index of the claiming fence (0 on a miss) |

## Verification
The bench targets the half-written fence, which a decoder that kept its enable in the high word, or that matched on the high word alone, would let claim addresses too early. It probes the first and last byte of a window and the first page past it, where an off-by-one comparison adds or drops a page. It also probes overlapping windows, where the wrong priority order reports the higher index. Random X and Y fences with many strides exercise the row split and the column split of the translation, where a swapped tile shape or a miscounted stride moves data into the wrong tile. Lookups issued right after the final low-word write show whether a new fence takes effect one cycle late.

// File: rtl/fence_pkg.sv
package fence_pkg;

  localparam int ADDR_W   = 32;
  localparam int PAGE_LSB = 12;
  localparam int PAGE_W   = ADDR_W - PAGE_LSB;
  localparam int PITCH_W  = 10;
  localparam int UNIT_LSB = 7;
  localparam int UNIT_W   = ADDR_W - UNIT_LSB;

  typedef struct packed {
    logic               en;
    logic               ytile;
    logic [PITCH_W-1:0] pitch;
    logic [PAGE_W-1:0]  first_pg;
    logic [PAGE_W-1:0]  last_pg;
  } fence_t;

  // Restoring division of a 128-byte unit count by the stride in units.
  function automatic logic [UNIT_W-1:0] div_units(
    input logic [UNIT_W-1:0]  num,
    input logic [PITCH_W:0]   den
  );
    logic [PITCH_W+1:0] rem;
    logic [UNIT_W-1:0]  q;
    rem = '0;
    q   = '0;
    for (int i = UNIT_W - 1; i >= 0; i--) begin
      rem = {rem[PITCH_W:0], num[i]};
      if (rem >= {1'b0, den}) begin
        rem  = rem - {1'b0, den};
        q[i] = 1'b1;
      end
    end
    return q;
  endfunction

endpackage

// File: rtl/fence_regfile.sv
module fence_regfile
  import fence_pkg::*;
#(
  parameter int NUM_FENCES = 8,
  localparam int IDX_W  = (NUM_FENCES > 1) ? $clog2(NUM_FENCES) : 1,
  localparam int WSEL_W = IDX_W + 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [WSEL_W-1:0]            waddr,
  input  logic [31:0]                  wdata,
  input  logic [WSEL_W-1:0]            raddr,
  output logic [31:0]                  rdata,
  output fence_t [NUM_FENCES-1:0]      fences
);

  for (genvar g = 0; g < NUM_FENCES; g++) begin : g_fence
    logic sel;
    assign sel = we && (waddr[WSEL_W-1:1] == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        fences[g] <= '0;
      end else if (sel) begin
        if (waddr[0]) begin
          fences[g].last_pg <= wdata[31:PAGE_LSB];
        end else begin
          fences[g].first_pg <= wdata[31:PAGE_LSB];
          fences[g].pitch    <= wdata[PITCH_W+1:2];
          fences[g].ytile    <= wdata[1];
          fences[g].en       <= wdata[0];
        end
      end
    end
  end

  logic [IDX_W-1:0] ridx;
  int               ri;
  fence_t           rsel;
  logic [31:0]      rword;

  always_comb begin
    ridx  = raddr[WSEL_W-1:1];
    ri    = int'(ridx);
    rsel  = '0;
    if (ri < NUM_FENCES) rsel = fences[ridx];
    if (raddr[0]) rword = {rsel.last_pg, 12'h000};
    else          rword = {rsel.first_pg, rsel.pitch, rsel.ytile, rsel.en};
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rword;
  end

endmodule

// File: rtl/fence_match.sv
module fence_match
  import fence_pkg::*;
#(
  parameter int NUM_FENCES = 8,
  localparam int IDX_W = (NUM_FENCES > 1) ? $clog2(NUM_FENCES) : 1
) (
  input  logic [PAGE_W-1:0]       page,
  input  fence_t [NUM_FENCES-1:0] fences,
  output logic                    hit,
  output logic [IDX_W-1:0]        idx
);

  logic [NUM_FENCES-1:0] claims;

  for (genvar g = 0; g < NUM_FENCES; g++) begin : g_cmp
    assign claims[g] = fences[g].en &&
                       (page >= fences[g].first_pg) &&
                       (page <= fences[g].last_pg);
  end

  always_comb begin
    idx = '0;
    for (int i = NUM_FENCES - 1; i >= 0; i--) begin
      if (claims[i]) idx = IDX_W'(i);
    end
    hit = |claims;
  end

endmodule

// File: rtl/fence_xlate.sv
module fence_xlate
  import fence_pkg::*;
(
  input  logic [ADDR_W-1:0] lin,
  input  fence_t            f,
  output logic [ADDR_W-1:0] tiled
);

  logic [31:0]        base, off, stride, x, yrow, rowoff, intile;
  logic [UNIT_W-1:0]  y;
  logic [PITCH_W:0]   units_per_row;

  always_comb begin
    base          = {f.first_pg, 12'h000};
    off           = lin - base;
    units_per_row = {1'b0, f.pitch} + 1'b1;
    y             = div_units(off[31:UNIT_LSB], units_per_row);
    stride        = {14'b0, units_per_row, 7'b0};
    x             = off - ({7'b0, y} * stride);
    if (f.ytile) begin
      yrow   = {7'b0, y[UNIT_W-1:5], 5'b0};
      intile = {x[26:7], 12'h000} + {20'b0, x[6:4], 9'b0} +
               {23'b0, y[4:0], 4'b0} + {28'b0, x[3:0]};
    end else begin
      yrow   = {7'b0, y[UNIT_W-1:3], 3'b0};
      intile = {x[28:9], 12'h000} + {20'b0, y[2:0], 9'b0} +
               {23'b0, x[8:0]};
    end
    rowoff = yrow * stride;
    tiled  = base + rowoff + intile;
  end

endmodule

// File: rtl/fence_decoder.sv
module fence_decoder
  import fence_pkg::*;
#(
  parameter int NUM_FENCES = 8,
  localparam int IDX_W  = (NUM_FENCES > 1) ? $clog2(NUM_FENCES) : 1,
  localparam int WSEL_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [WSEL_W-1:0] cfg_waddr,
  input  logic [31:0]       cfg_wdata,
  input  logic [WSEL_W-1:0] cfg_raddr,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  output logic              rsp_valid,
  output logic [31:0]       rsp_addr,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_fence
);

  fence_t [NUM_FENCES-1:0] fences;
  logic                    hit;
  logic [IDX_W-1:0]        hidx;
  fence_t                  chosen;
  logic [31:0]             xaddr;

  fence_regfile #(.NUM_FENCES(NUM_FENCES)) regs_i (
    .clk(clk), .rst(rst), .we(cfg_we), .waddr(cfg_waddr), .wdata(cfg_wdata),
    .raddr(cfg_raddr), .rdata(cfg_rdata), .fences(fences)
  );

  fence_match #(.NUM_FENCES(NUM_FENCES)) match_i (
    .page(req_addr[31:PAGE_LSB]), .fences(fences), .hit(hit), .idx(hidx)
  );

  assign chosen = fences[hidx];

  fence_xlate xlate_i (
    .lin(req_addr), .f(chosen), .tiled(xaddr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_hit   <= 1'b0;
      rsp_fence <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= hit;
      rsp_fence <= hit ? hidx : '0;
      rsp_addr  <= hit ? xaddr : req_addr;
    end
  end

endmodule

// File: rtl/fence_decoder_chk.sv
module fence_decoder_chk #(
  parameter int NUM_FENCES = 8,
  localparam int IDX_W  = (NUM_FENCES > 1) ? $clog2(NUM_FENCES) : 1,
  localparam int WSEL_W = IDX_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic [WSEL_W-1:0] cfg_raddr,
  input logic [31:0]       cfg_rdata,
  input logic              req_valid,
  input logic [31:0]       req_addr,
  input logic              rsp_valid,
  input logic [31:0]       rsp_addr,
  input logic              rsp_hit
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && !rsp_hit && cfg_rdata == 32'h0));

  assert_hi_reserved_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_raddr[0] |=> (cfg_rdata[11:0] == 12'h000));

  assert_miss_passthru_R6: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_hit || rsp_addr == $past(req_addr)));

  // R7 and R8: both tile shapes keep the 16-byte offset intact
  assert_low_bits_kept_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!rsp_hit || rsp_addr[3:0] == $past(req_addr[3:0])));

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_idle_follows_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

endmodule

bind fence_decoder fence_decoder_chk #(.NUM_FENCES(NUM_FENCES)) chk_i (
  .clk(clk), .rst(rst), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
  .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_addr(rsp_addr), .rsp_hit(rsp_hit)
);

// File: tb/fence_decoder_tb.sv
module fence_decoder_tb_top;

  localparam int N      = 8;
  localparam int IDX_W  = $clog2(N);
  localparam int WSEL_W = IDX_W + 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [WSEL_W-1:0] cfg_waddr = '0;
  logic [31:0]       cfg_wdata = '0;
  logic [WSEL_W-1:0] cfg_raddr = '0;
  logic [31:0]       cfg_rdata;
  logic              req_valid = 1'b0;
  logic [31:0]       req_addr = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_addr;
  logic              rsp_hit;
  logic [IDX_W-1:0]  rsp_fence;

  always #4 clk = ~clk;

  fence_decoder #(.NUM_FENCES(N)) dut_i (.*);

  int    vectors = 0;
  int    errors  = 0;
  string phase   = "R1";
  bit    done    = 0;

  // behavioural model state
  bit [31:0] m_lo [N];
  bit [31:0] m_hi [N];
  bit        e_valid, e_hit, e_rst, e_y;
  bit [31:0] e_addr, e_rdata;
  int        e_fence;

  function automatic bit [31:0] model_tile(bit [31:0] a, bit [31:0] lo);
    longint start, o, s, y, x, tile, inner;
    start = longint'(lo & 32'hFFFF_F000);
    s     = (longint'((lo >> 2) & 32'h3FF) + 1) * 128;
    o     = longint'(a) - start;
    y     = o / s;
    x     = o % s;
    if (lo[1]) begin
      tile  = (y / 32) * (s / 128) + x / 128;
      inner = ((x % 128) / 16) * 512 + (y % 32) * 16 + (x % 16);
    end else begin
      tile  = (y / 8) * (s / 512) + x / 512;
      inner = (y % 8) * 512 + (x % 512);
    end
    return 32'(start + tile * 4096 + inner);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin m_lo[i] = 0; m_hi[i] = 0; end
      e_valid = 0; e_hit = 0; e_addr = 0; e_fence = 0; e_rdata = 0; e_rst = 1; e_y = 0;
    end else begin
      e_rst   = 0;
      e_valid = req_valid;
      e_hit   = 0;
      e_fence = 0;
      e_addr  = req_addr;
      e_y     = 0;
      for (int i = N - 1; i >= 0; i--) begin
        if (m_lo[i][0] && req_addr[31:12] >= m_lo[i][31:12] &&
            req_addr[31:12] <= m_hi[i][31:12]) begin
          e_hit = 1; e_fence = i;
        end
      end
      if (e_hit) begin
        e_addr = model_tile(req_addr, m_lo[e_fence]);
        e_y    = m_lo[e_fence][1];
      end
      e_rdata = cfg_raddr[0] ? m_hi[cfg_raddr[WSEL_W-1:1]] : m_lo[cfg_raddr[WSEL_W-1:1]];
      if (cfg_we) begin
        if (cfg_waddr[0]) m_hi[cfg_waddr[WSEL_W-1:1]] = cfg_wdata & 32'hFFFF_F000;
        else              m_lo[cfg_waddr[WSEL_W-1:1]] = cfg_wdata;
      end
    end
  end

  task automatic check(string req, bit ok, bit [31:0] act, bit [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual=%h expected=%h", req, phase, act, exp);
    end
  endtask

  // per-clock comparison, sampled away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      string t;
      t = e_rst ? "R1" : "R9";
      check(t, rsp_valid == e_valid, 32'(rsp_valid), 32'(e_valid));
      check(e_rst ? "R1" : "R2", cfg_rdata == e_rdata, cfg_rdata, e_rdata);
      if (e_valid) begin
        check(e_hit ? "R4" : "R6", rsp_hit == e_hit, 32'(rsp_hit), 32'(e_hit));
        if (e_hit) begin
          check("R5", int'(rsp_fence) == e_fence, 32'(rsp_fence), 32'(e_fence));
          check(e_y ? "R8" : "R7", rsp_addr == e_addr, rsp_addr, e_addr);
        end else begin
          check("R6", rsp_addr == e_addr, rsp_addr, e_addr);
        end
      end
    end
  end

  task automatic wr(int idx, bit hi, bit [31:0] d);
    cfg_we = 1; cfg_waddr = {IDX_W'(idx), hi}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic look(bit [31:0] a);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic rd(int idx, bit hi);
    cfg_raddr = {IDX_W'(idx), hi};
    @(negedge clk);
  endtask

  task automatic program_fence(int idx, bit [31:0] lo, bit [31:0] hi);
    wr(idx, 0, 32'h0);
    wr(idx, 1, hi);
    wr(idx, 0, lo);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", rsp_valid == 0 && cfg_rdata == 0, {31'b0, rsp_valid}, 32'h0);
    rst = 0;
    @(negedge clk);
    check("R1", cfg_rdata == 0, cfg_rdata, 32'h0);

    // safe sequence on fence 2, X tiling, stride 2048, 64 KB
    phase = "R3";
    wr(2, 0, 32'h0);
    wr(2, 1, 32'h0010_F000);
    look(32'h0010_0040);
    check("R3", rsp_hit == 0, 32'(rsp_hit), 32'h0);
    check("R3", rsp_addr == 32'h0010_0040, rsp_addr, 32'h0010_0040);

    phase = "R10";
    cfg_we = 1; cfg_waddr = {IDX_W'(2), 1'b0}; cfg_wdata = 32'h0010_003D;
    @(negedge clk);
    cfg_we = 0;
    look(32'h0010_4A58);
    check("R10", rsp_hit == 1, 32'(rsp_hit), 32'h1);
    check("R7", rsp_addr == 32'h0010_5258, rsp_addr, 32'h0010_5258);

    phase = "R2";
    rd(2, 0);
    check("R2", cfg_rdata == 32'h0010_003D, cfg_rdata, 32'h0010_003D);
    wr(2, 1, 32'h0010_FABC);
    rd(2, 1);
    check("R2", cfg_rdata == 32'h0010_F000, cfg_rdata, 32'h0010_F000);

    phase = "R4";
    look(32'h0010_0000);
    check("R4", rsp_hit == 1, 32'(rsp_hit), 32'h1);
    look(32'h0010_FFFF);
    check("R4", rsp_hit == 1, 32'(rsp_hit), 32'h1);
    look(32'h0011_0000);
    check("R4", rsp_hit == 0, 32'(rsp_hit), 32'h0);
    look(32'h000F_FFFF);
    check("R4", rsp_hit == 0, 32'(rsp_hit), 32'h0);

    // Y tiling on fence 5: stride 512, 32 KB
    phase = "R8";
    program_fence(5, 32'h0020_000F, 32'h0020_7000);
    look(32'h0020_50C8);
    check("R8", rsp_addr == 32'h0020_5888, rsp_addr, 32'h0020_5888);
    check("R5", rsp_fence == 3'd5, 32'(rsp_fence), 32'h5);

    // overlap: fence 1 covers one page inside fence 2
    phase = "R5";
    program_fence(1, 32'h0010_800D, 32'h0010_8000);
    look(32'h0010_8100);
    check("R5", rsp_fence == 3'd1, 32'(rsp_fence), 32'h1);
    look(32'h0010_9100);
    check("R5", rsp_fence == 3'd2, 32'(rsp_fence), 32'h2);

    // clearing: low word first, then high
    phase = "R3";
    wr(1, 0, 32'h0);
    look(32'h0010_8100);
    check("R3", rsp_fence == 3'd2, 32'(rsp_fence), 32'h2);
    wr(1, 1, 32'h0);
    wr(2, 0, 32'h0);
    look(32'h0010_8100);
    check("R6", rsp_hit == 0 && rsp_addr == 32'h0010_8100, rsp_addr, 32'h0010_8100);

    phase = "R9";
    repeat (3) @(negedge clk);
    check("R9", rsp_valid == 0, 32'(rsp_valid), 32'h0);

    // random fences and lookups
    phase = "random";
    for (int it = 0; it < 300; it++) begin
      int idx, pitch, rows;
      bit yt;
      bit [31:0] start, rowb, raw, sz;
      idx   = int'($urandom % N);
      yt    = 1'($urandom % 2);
      pitch = yt ? int'($urandom % 16) : int'(4 * ($urandom % 4 + 1) - 1);
      rowb  = 32'((pitch + 1) * 128 * (yt ? 32 : 8));
      start = 32'h0010_0000 + (($urandom % 32) << 12);
      raw   = rowb + ($urandom % (4 * rowb));
      sz    = (raw / rowb) * rowb;
      rows  = int'(sz / rowb);
      if (rows > 0)
        program_fence(idx, start | 32'(pitch << 2) | {30'b0, yt, 1'b1}, start + sz - 32'h1000);
      for (int k = 0; k < 6; k++) begin
        req_valid = ($urandom % 4) != 0;
        req_addr  = 32'h0010_0000 + ($urandom % 32'h0020_0000);
        cfg_raddr = WSEL_W'($urandom);
        @(negedge clk);
      end
      req_valid = 0;
    end

    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule